// File: doc/BRIEF.md
# Lane Write-Mask Decoder

This block turns a compact write-enable request into a 64-bit byte-enable vector for one 64-byte register row. The request has a selection mode, a count or index value N, and a lane width of 1, 2, 4 or 8 bytes. The decoder works out which lanes of the row are enabled and sets every byte that belongs to an enabled lane. A datapath uses the result to merge a freshly produced row into a destination register. The decoder also raises a flag when the request asks for every lane to be written with zero data in place of the computed values.

Two request encodings are accepted. The wide format has a 3-bit mode and a 6-bit value. The narrow format has a 2-bit mode and a 5-bit value, and it offers a smaller set of mode-0 patterns. A separate half-lane input keeps only the low byte of each 16-bit lane. The decode is combinational, and its result is captured in one output register stage with a synchronous active-high reset.

Top module: `wm_lane_mask`

## Requirements
- R1: While `rst` is high at a rising edge, `byte_en` and `zero_data` become 0. Otherwise both outputs show the decode of the inputs sampled at the previous rising edge (one cycle of latency).
- R2: In the wide format (`fmt_wide`=1) with mode 0, value 0, 4 or 5 enables all lanes. Value 1 enables only odd lanes, value 2 enables only even lanes, value 3 enables all lanes, and any other value enables no lanes.
- R3: `zero_data` is 1 only for a wide-format request with mode 0 and value 3. It is 0 for every other request, including narrow-format mode 0 with value 3.
- R4: Mode 1 enables only lane N. If N is not smaller than the lane count, no lane is enabled.
- R5: Mode 2 enables lanes 0 to N-1. N=0 enables all lanes, and an N above the lane count is clamped to the lane count.
- R6: Mode 3 enables the last N lanes. N=0 enables all lanes, and an N above the lane count is clamped to the lane count.
- R7: In the wide format, mode 4 enables the first N lanes and mode 5 enables the last N lanes. For both modes, N=0 enables no lane, and N is clamped to the lane count.
- R8: In the wide format, modes 6 and 7 enable no lanes.
- R9: In the narrow format (`fmt_wide`=0), only `mode[1:0]` and `value[4:0]` are used, and `mode[2]` and `value[5]` are ignored. Mode 0 with value 0 enables all lanes, value 1 enables odd lanes, value 2 enables even lanes, and any other value enables none. Modes 1 to 3 behave as in R4 to R6.
- R10: `lane_w` codes 0, 1, 2 and 3 select 1, 2, 4 and 8 bytes per lane. The lane count is 64 divided by the lane size. Lane i covers bytes i*size to i*size+size-1, and an enabled lane sets all of its bytes.
- R11: When `half_lane` is 1, every odd-numbered bit of `byte_en` is 0, and the even bits are left as the decode gives them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fmt_wide | input | 1 | 1 = wide request format, 0 = narrow |
| mode | input | 3 | Selection mode (bit 2 unused in narrow format) |
| value | input | 6 | N: count, index or pattern code (bit 5 unused in narrow format) |
| lane_w | input | 2 | Lane size code: 0/1/2/3 = 1/2/4/8 bytes |
| half_lane | input | 1 | Keep only the low byte of each 16-bit lane |
| byte_en | output | 64 | Registered byte enables, bit b for byte b |
| zero_data | output | 1 | Registered flag: write zeros to all enabled bytes |

## Verification
A wrong internal decode shows up at `byte_en` exactly one cycle after the offending request. Because the result holds no state from one request to the next, a fault cannot stay hidden and surface later. The bench compares the full vector and the flag on every cycle, so the first bad cycle is reported. The mismatches to look for are a clamping error, which gives a lane boundary off by one, a lane-size error, which gives a stretched or shrunk group of bytes, and a swapped zero-count meaning between modes 2/3 and 4/5, which gives an all-ones vector where an all-zero one was due.

// File: rtl/wm_pkg.sv
package wm_pkg;
    localparam int ROW_BYTES  = 64;
    localparam int CNT_W      = $clog2(ROW_BYTES) + 1;
    localparam int WMODE_W    = 3;
    localparam int WVAL_W     = 6;
    localparam int NMODE_W    = 2;
    localparam int NVAL_W     = 5;
    localparam int LW_W       = 2;

    typedef enum logic [LW_W-1:0] {
        LW_B1 = 2'd0,
        LW_B2 = 2'd1,
        LW_B4 = 2'd2,
        LW_B8 = 2'd3
    } lane_w_e;

    typedef enum logic [WMODE_W-1:0] {
        SEL_PATTERN   = 3'd0,
        SEL_ONE       = 3'd1,
        SEL_HEAD_ALL0 = 3'd2,
        SEL_TAIL_ALL0 = 3'd3,
        SEL_HEAD_NON0 = 3'd4,
        SEL_TAIL_NON0 = 3'd5,
        SEL_OFF_A     = 3'd6,
        SEL_OFF_B     = 3'd7
    } sel_e;

    typedef enum logic [2:0] {
        PAT_ALL,
        PAT_ODD,
        PAT_EVEN,
        PAT_ZERO,
        PAT_NONE
    } pat_e;

    typedef struct packed {
        sel_e              sel;
        pat_e              pat;
        logic [CNT_W-1:0]  n;
    } req_t;

    function automatic logic [CNT_W-1:0] lane_count(lane_w_e w);
        return CNT_W'(ROW_BYTES) >> w;
    endfunction
endpackage

// File: rtl/wm_req_norm.sv
module wm_req_norm
    import wm_pkg::*;
(
    input  logic               fmt_wide,
    input  logic [WMODE_W-1:0] mode,
    input  logic [WVAL_W-1:0]  value,
    output req_t               req
);
    logic [WMODE_W-1:0] mode_eff;
    logic [WVAL_W-1:0]  val_eff;

    always_comb begin
        if (fmt_wide) begin
            mode_eff = mode;
            val_eff  = value;
        end else begin
            mode_eff = {{(WMODE_W-NMODE_W){1'b0}}, mode[NMODE_W-1:0]};
            val_eff  = {{(WVAL_W-NVAL_W){1'b0}}, value[NVAL_W-1:0]};
        end
    end

    always_comb begin
        req.sel = sel_e'(mode_eff);
        req.n   = CNT_W'(val_eff);
        case (val_eff)
            6'd0:    req.pat = PAT_ALL;
            6'd1:    req.pat = PAT_ODD;
            6'd2:    req.pat = PAT_EVEN;
            6'd3:    req.pat = fmt_wide ? PAT_ZERO : PAT_NONE;
            6'd4,
            6'd5:    req.pat = fmt_wide ? PAT_ALL : PAT_NONE;
            default: req.pat = PAT_NONE;
        endcase
    end
endmodule

// File: rtl/wm_lane_select.sv
module wm_lane_select
    import wm_pkg::*;
(
    input  req_t                 req,
    input  lane_w_e              lane_w,
    output logic [ROW_BYTES-1:0] lane_on,
    output logic                 zero_flag
);
    logic [CNT_W-1:0] lanes;
    logic [CNT_W-1:0] n_clamp;
    logic [CNT_W-1:0] tail_start;

    always_comb begin
        lanes      = lane_count(lane_w);
        n_clamp    = (req.n > lanes) ? lanes : req.n;
        tail_start = lanes - n_clamp;
        zero_flag  = (req.sel == SEL_PATTERN) && (req.pat == PAT_ZERO);
    end

    for (genvar i = 0; i < ROW_BYTES; i++) begin : g_lane
        localparam logic [CNT_W-1:0] IDX = CNT_W'(i);
        logic in_row;
        logic hit;
        assign in_row = IDX < lanes;
        always_comb begin
            case (req.sel)
                SEL_PATTERN: begin
                    case (req.pat)
                        PAT_ALL,
                        PAT_ZERO: hit = 1'b1;
                        PAT_ODD:  hit = IDX[0];
                        PAT_EVEN: hit = ~IDX[0];
                        default:  hit = 1'b0;
                    endcase
                end
                SEL_ONE:       hit = (req.n == IDX);
                SEL_HEAD_ALL0: hit = (req.n == '0) || (IDX < n_clamp);
                SEL_TAIL_ALL0: hit = (req.n == '0) || (IDX >= tail_start);
                SEL_HEAD_NON0: hit = IDX < n_clamp;
                SEL_TAIL_NON0: hit = IDX >= tail_start;
                default:       hit = 1'b0;
            endcase
        end
        assign lane_on[i] = in_row && hit;
    end
endmodule

// File: rtl/wm_byte_expand.sv
module wm_byte_expand
    import wm_pkg::*;
(
    input  logic [ROW_BYTES-1:0] lane_on,
    input  lane_w_e              lane_w,
    output logic [ROW_BYTES-1:0] byte_en
);
    for (genvar b = 0; b < ROW_BYTES; b++) begin : g_byte
        always_comb begin
            case (lane_w)
                LW_B1:   byte_en[b] = lane_on[b];
                LW_B2:   byte_en[b] = lane_on[b >> 1];
                LW_B4:   byte_en[b] = lane_on[b >> 2];
                default: byte_en[b] = lane_on[b >> 3];
            endcase
        end
    end
endmodule

// File: rtl/wm_lane_mask.sv
module wm_lane_mask
    import wm_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 fmt_wide,
    input  logic [WMODE_W-1:0]   mode,
    input  logic [WVAL_W-1:0]    value,
    input  logic [LW_W-1:0]      lane_w,
    input  logic                 half_lane,
    output logic [ROW_BYTES-1:0] byte_en,
    output logic                 zero_data
);
    localparam logic [ROW_BYTES-1:0] LOW_BYTE_KEEP = {(ROW_BYTES/2){2'b01}};

    req_t                 req;
    logic [ROW_BYTES-1:0] lane_on;
    logic [ROW_BYTES-1:0] raw_en;
    logic [ROW_BYTES-1:0] next_en;
    logic                 zero_flag;

    wm_req_norm u_norm (
        .fmt_wide (fmt_wide),
        .mode     (mode),
        .value    (value),
        .req      (req)
    );

    wm_lane_select u_sel (
        .req       (req),
        .lane_w    (lane_w_e'(lane_w)),
        .lane_on   (lane_on),
        .zero_flag (zero_flag)
    );

    wm_byte_expand u_exp (
        .lane_on (lane_on),
        .lane_w  (lane_w_e'(lane_w)),
        .byte_en (raw_en)
    );

    assign next_en = half_lane ? (raw_en & LOW_BYTE_KEEP) : raw_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            byte_en   <= '0;
            zero_data <= 1'b0;
        end else begin
            byte_en   <= next_en;
            zero_data <= zero_flag;
        end
    end
endmodule

// File: rtl/wm_lane_mask_chk.sv
module wm_lane_mask_chk
    import wm_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 fmt_wide,
    input logic [WMODE_W-1:0]   mode,
    input logic [WVAL_W-1:0]    value,
    input logic                 half_lane,
    input logic [ROW_BYTES-1:0] byte_en,
    input logic                 zero_data
);
    localparam logic [ROW_BYTES-1:0] ODD_BYTES = {(ROW_BYTES/2){2'b10}};

    p_reset_clear_r1: assert property (@(posedge clk)
        $past(rst) |-> (byte_en == '0 && !zero_data));

    p_zero_only_wide3_r3: assert property (@(posedge clk) disable iff (rst)
        zero_data |-> $past(fmt_wide && mode == 3'd0 && value == 6'd3));

    p_zero_all_lanes_r2: assert property (@(posedge clk) disable iff (rst)
        (zero_data && !$past(half_lane)) |-> (byte_en == '1));

    p_single_lane_r4: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst && mode[1:0] == 2'd1 && (fmt_wide ? mode[2] == 1'b0 : 1'b1)))
        |-> ($countones(byte_en) <= 8));

    p_off_modes_r8: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && fmt_wide && mode[2:1] == 2'b11) |-> (byte_en == '0));

    p_half_lane_r11: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && half_lane) |-> ((byte_en & ODD_BYTES) == '0));
endmodule

bind wm_lane_mask wm_lane_mask_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .fmt_wide  (fmt_wide),
    .mode      (mode),
    .value     (value),
    .half_lane (half_lane),
    .byte_en   (byte_en),
    .zero_data (zero_data)
);

// File: tb/wm_lane_mask_bench.sv
module wm_lane_mask_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        fmt_wide;
    logic [2:0]  mode;
    logic [5:0]  value;
    logic [1:0]  lane_w;
    logic        half_lane;
    logic [63:0] byte_en;
    logic        zero_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    wm_lane_mask u_wm_lane_mask (
        .clk(clk), .rst(rst), .fmt_wide(fmt_wide), .mode(mode), .value(value),
        .lane_w(lane_w), .half_lane(half_lane), .byte_en(byte_en), .zero_data(zero_data)
    );

    // Behavioural model built from the requirements.
    function automatic logic [64:0] model(bit w, int md, int v, int lw, bit half);
        logic [63:0] en = '0;
        bit zf = 0;
        int size = 1 << lw;
        int cnt = 64 / size;
        int n, nc;
        if (!w) begin md = md % 4; v = v % 32; end
        n  = v;
        nc = (n > cnt) ? cnt : n;
        for (int i = 0; i < cnt; i++) begin
            bit on = 0;
            case (md)
                0: begin
                    if (v == 0 || (w && (v == 4 || v == 5))) on = 1;
                    else if (v == 1) on = (i % 2 == 1);
                    else if (v == 2) on = (i % 2 == 0);
                    else if (v == 3 && w) begin on = 1; zf = 1; end
                end
                1: on = (i == n);
                2: on = (n == 0) || (i < nc);
                3: on = (n == 0) || (i >= cnt - nc);
                4: on = (i < nc);
                5: on = (i >= cnt - nc);
                default: on = 0;
            endcase
            if (on) for (int b = 0; b < size; b++) en[i*size + b] = 1'b1;
        end
        if (half) for (int b = 1; b < 64; b += 2) en[b] = 1'b0;
        return {zf, en};
    endfunction

    task automatic apply(string tag, bit w, int md, int v, int lw, bit half);
        logic [64:0] exp;
        @(negedge clk);
        fmt_wide = w; mode = md[2:0]; value = v[5:0]; lane_w = lw[1:0]; half_lane = half;
        exp = model(w, md, v, lw, half);
        @(negedge clk);
        checks++;
        if ({zero_data, byte_en} !== exp) begin
            fails++;
            $display("FAIL %s: w=%0d mode=%0d val=%0d lw=%0d half=%0d got zf=%0b en=%h exp zf=%0b en=%h",
                     tag, w, md, v, lw, half, zero_data, byte_en, exp[64], exp[63:0]);
        end
    endtask

    initial begin
        rst = 1'b1; fmt_wide = 1; mode = 0; value = 0; lane_w = 0; half_lane = 0;
        @(negedge clk); @(negedge clk);
        checks++;
        if (byte_en !== '0 || zero_data !== 1'b0) begin
            fails++;
            $display("FAIL R1: reset got en=%h zf=%0b exp en=0 zf=0", byte_en, zero_data);
        end
        rst = 1'b0;
        // R2 / R3: wide mode 0 patterns
        for (int v = 0; v < 8; v++) apply("R2", 1, 0, v, 1, 0);
        apply("R3", 1, 0, 3, 3, 0);
        apply("R3", 0, 0, 3, 0, 0);
        // R4: single lane, including out-of-range index
        apply("R4", 1, 1, 5, 0, 0);
        apply("R4", 1, 1, 7, 3, 0);
        apply("R4", 1, 1, 8, 3, 0);
        apply("R4", 1, 1, 63, 0, 0);
        // R5 / R6: N=0 all, clamp
        apply("R5", 1, 2, 0, 2, 0);
        apply("R5", 1, 2, 3, 2, 0);
        apply("R5", 1, 2, 40, 2, 0);
        apply("R6", 1, 3, 0, 1, 0);
        apply("R6", 1, 3, 5, 1, 0);
        apply("R6", 1, 3, 50, 3, 0);
        // R7: N=0 none, clamp
        apply("R7", 1, 4, 0, 0, 0);
        apply("R7", 1, 4, 9, 0, 0);
        apply("R7", 1, 5, 0, 2, 0);
        apply("R7", 1, 5, 3, 2, 0);
        apply("R7", 1, 5, 20, 3, 0);
        // R8: off modes
        apply("R8", 1, 6, 0, 0, 0);
        apply("R8", 1, 7, 2, 1, 0);
        // R9: narrow format, ignored high bits
        apply("R9", 0, 0, 0, 1, 0);
        apply("R9", 0, 0, 1, 0, 0);
        apply("R9", 0, 0, 2, 2, 0);
        apply("R9", 0, 0, 4, 0, 0);
        apply("R9", 0, 0, 33, 0, 0);
        apply("R9", 0, 5, 6, 1, 0);
        apply("R9", 0, 6, 0, 0, 0);
        apply("R9", 0, 7, 40, 0, 0);
        // R10: every lane size for one request shape
        for (int lw = 0; lw < 4; lw++) apply("R10", 1, 3, 3, lw, 0);
        for (int lw = 0; lw < 4; lw++) apply("R10", 1, 0, 1, lw, 0);
        // R11: half-lane keep
        apply("R11", 1, 0, 0, 1, 1);
        apply("R11", 1, 0, 3, 1, 1);
        apply("R11", 1, 2, 10, 0, 1);
        // sweep
        for (int md = 0; md < 8; md++)
            for (int v = 0; v < 64; v += 7)
                apply("R10", md % 2, md, v, (md + v) % 4, (v % 3) == 0);
        // R1: reset in mid-run clears outputs
        @(negedge clk);
        fmt_wide = 1; mode = 0; value = 0; rst = 1'b1;
        @(negedge clk);
        checks++;
        if (byte_en !== '0 || zero_data !== 1'b0) begin
            fails++;
            $display("FAIL R1: mid reset got en=%h zf=%0b exp en=0 zf=0", byte_en, zero_data);
        end
        rst = 1'b0;
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule